// File: doc/BRIEF.md
# Flat Page-Table Address Translator

This block turns a device-side virtual address into a physical address by looking it up in a single-level table held in memory. Each table word describes one 4 KB page, and the table spans the whole 32-bit virtual space, so a lookup always costs exactly one memory read. The table base comes from a register loaded through a write strobe. The register resets to zero, and a zero base means that no table is installed.

A client hands in a virtual address on a ready/valid request channel. The block works out which table word to fetch and issues one read on its memory port. It then checks the returned word and presents the result on a ready/valid response channel. A valid word yields the page frame from the word joined to the page offset of the request. A zero word, a word without the valid flag, or a request made while the base is zero yields a fault. A faulting access is steered to a protect address aligned to 128 bytes. Every response also carries the page-aligned virtual address, so that a separate capture block can record where a fault happened. The block works on one translation at a time.

The controller has four states. `XL_IDLE` accepts a request. It moves to `XL_ISSUE` when the base is nonzero, or straight to `XL_REPLY` with a fault when the base is zero. `XL_ISSUE` holds the table read until the memory accepts it and then moves to `XL_AWAIT`. `XL_AWAIT` moves to `XL_REPLY` when the table word arrives. `XL_REPLY` holds the result until the client takes it and then returns to `XL_IDLE`.

Top module: `pt_xlate_top`

## Requirements
- R1: After reset, `req_ready` is 1, `resp_valid` is 0 and `mem_rd_valid` is 0.
- R2: The table word is read at byte address base + (va[31:12] × 4), wrapping modulo 2^32. Bits [1:0] of a value written to the base are dropped. The address is fixed when the request is accepted, so a base write made after acceptance does not change it.
- R3: Only one translation is in flight. `req_ready` is high only in the idle state, and it returns high only after the response handshake completes.
- R4: A table word that is nonzero with bit 1 (valid) set gives `resp_fault`=0 and `resp_pa` = {word[31:12], va[11:0]}.
- R5: A table word equal to zero, or with bit 1 clear, gives `resp_fault`=1.
- R6: On a fault, `resp_pa` equals `prot_addr` with bits [6:0] cleared.
- R7: A request accepted while the base register is zero faults without issuing any memory read.
- R8: `resp_nonsec` equals bit 3 of the table word on a successful translation and is 0 on a fault.
- R9: `resp_page_va` equals the request address with bits [11:0] cleared, for faults and successes alike.
- R10: While `mem_rd_valid` is high and `mem_rd_ready` is low, the read request and its address stay unchanged. While `resp_valid` is high and `resp_ready` is low, the response fields stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tbl_base_wr | input | 1 | Load strobe for the table base register |
| tbl_base_in | input | 32 | New table base; bits [1:0] are dropped |
| prot_addr | input | 32 | Protect address used on a fault; bits [6:0] are ignored |
| req_valid | input | 1 | Client request valid |
| req_ready | output | 1 | Block can accept a request |
| req_va | input | 32 | Virtual address to translate |
| resp_valid | output | 1 | Translation result valid |
| resp_ready | input | 1 | Client takes the result |
| resp_pa | output | 32 | Physical address, or the aligned protect address on a fault |
| resp_fault | output | 1 | Translation fault |
| resp_nonsec | output | 1 | Page marked non-secure |
| resp_page_va | output | 32 | Request address with the page offset cleared |
| mem_rd_valid | output | 1 | Table read request valid |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 32 | Byte address of the table word |
| mem_rsp_valid | input | 1 | Table word returned |
| mem_rsp_data | input | 32 | Table word |

## Verification
On every cycle, the assertions check several properties against the base value and virtual address captured at acceptance: the table-read address, the single-outstanding rule, the fault verdict that follows each returned word, the offset and frame carried into a good result, the cleared non-secure flag and aligned redirect on a fault, the page-aligned virtual address, and both hold rules. Some points only the bench scenarios can show. These are that a base written in mid-flight does not disturb the pending read, that a zero base issues no memory read at all, the exact redirect value taken from the protect input, and the reset state of the ports. The bench sweeps every table-word position modulo 32 under several bases, including an unaligned one and one that wraps, with varied memory and client stalls.

// File: rtl/pt_xlate_pkg.sv
package pt_xlate_pkg;

    // Controller states of the single-outstanding translator
    typedef enum logic [1:0] {
        XL_IDLE  = 2'd0,
        XL_ISSUE = 2'd1,
        XL_AWAIT = 2'd2,
        XL_REPLY = 2'd3
    } xl_state_e;

    // Verdict flags that travel with a translation result
    typedef struct packed {
        logic fault;
        logic nonsec;
    } xl_flags_t;

endpackage

// File: rtl/pt_base_reg.sv
module pt_base_reg #(
    parameter int ADDR_W      = 32,
    parameter int ENTRY_SHIFT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base_in,
    output logic [ADDR_W-1:0] base_q,
    output logic              base_is_zero
);
    localparam logic [ADDR_W-1:0] LOW_ONES = ADDR_W'((1 << ENTRY_SHIFT) - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
        end else if (load) begin
            base_q <= base_in & ~LOW_ONES;
        end
    end

    assign base_is_zero = (base_q == '0);

endmodule

// File: rtl/pt_entry_addr.sv
module pt_entry_addr #(
    parameter int ADDR_W      = 32,
    parameter int PAGE_SHIFT  = 12,
    parameter int ENTRY_SHIFT = 2
) (
    input  logic [ADDR_W-PAGE_SHIFT-1:0] vpn,
    input  logic [ADDR_W-1:0]            base,
    output logic [ADDR_W-1:0]            entry_addr
);
    localparam int VPN_W = ADDR_W - PAGE_SHIFT;
    localparam int GAP_W = PAGE_SHIFT - ENTRY_SHIFT;

    logic [ADDR_W-1:0] index_bytes;

    generate
        if (GAP_W > 0) begin : g_pad
            assign index_bytes = {{GAP_W{1'b0}}, vpn, {ENTRY_SHIFT{1'b0}}};
        end else begin : g_nopad
            assign index_bytes = {vpn[VPN_W+GAP_W-1:0], {ENTRY_SHIFT{1'b0}}};
        end
    endgenerate

    assign entry_addr = base + index_bytes;

endmodule

// File: rtl/pt_entry_decode.sv
module pt_entry_decode
    import pt_xlate_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int PAGE_SHIFT = 12,
    parameter int VALID_BIT  = 1,
    parameter int NONSEC_BIT = 3,
    parameter int PROT_SHIFT = 7
) (
    input  logic [ADDR_W-1:0]     entry,
    input  logic [PAGE_SHIFT-1:0] va_off,
    input  logic                  force_fault,
    input  logic [ADDR_W-1:0]     prot_addr,
    output logic [ADDR_W-1:0]     pa,
    output xl_flags_t             flags
);
    localparam logic [ADDR_W-1:0] PROT_MASK = ~ADDR_W'((1 << PROT_SHIFT) - 1);

    logic bad;

    always_comb begin
        bad          = force_fault || (entry == '0) || !entry[VALID_BIT];
        flags.fault  = bad;
        flags.nonsec = !bad && entry[NONSEC_BIT];
        if (bad) begin
            pa = prot_addr & PROT_MASK;
        end else begin
            pa = {entry[ADDR_W-1:PAGE_SHIFT], va_off};
        end
    end

endmodule

// File: rtl/pt_walk_fsm.sv
module pt_walk_fsm
    import pt_xlate_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int PAGE_SHIFT = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [ADDR_W-1:0]     req_va,
    input  logic                  base_zero,
    input  logic [ADDR_W-1:0]     entry_addr,
    output logic                  mem_rd_valid,
    input  logic                  mem_rd_ready,
    output logic [ADDR_W-1:0]     mem_rd_addr,
    input  logic                  mem_rsp_valid,
    input  logic [ADDR_W-1:0]     mem_rsp_data,
    output logic [ADDR_W-1:0]     dec_entry,
    output logic                  dec_force,
    output logic [PAGE_SHIFT-1:0] dec_off,
    input  logic [ADDR_W-1:0]     dec_pa,
    input  xl_flags_t             dec_flags,
    output logic                  resp_valid,
    input  logic                  resp_ready,
    output logic [ADDR_W-1:0]     resp_pa,
    output logic                  resp_fault,
    output logic                  resp_nonsec,
    output logic [ADDR_W-1:0]     resp_page_va
);
    xl_state_e         state_q, state_d;
    logic [ADDR_W-1:0] va_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] pa_q;
    xl_flags_t         flag_q;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XL_IDLE:  if (req_valid)     state_d = base_zero ? XL_REPLY : XL_ISSUE;
            XL_ISSUE: if (mem_rd_ready)  state_d = XL_AWAIT;
            XL_AWAIT: if (mem_rsp_valid) state_d = XL_REPLY;
            XL_REPLY: if (resp_ready)    state_d = XL_IDLE;
            default:                     state_d = XL_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= XL_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Handshake outputs decoded from the state
    always_comb begin
        req_ready    = 1'b0;
        mem_rd_valid = 1'b0;
        resp_valid   = 1'b0;
        unique case (state_q)
            XL_IDLE:  req_ready    = 1'b1;
            XL_ISSUE: mem_rd_valid = 1'b1;
            XL_AWAIT: ;
            XL_REPLY: resp_valid   = 1'b1;
            default:  ;
        endcase
    end

    // Decoder feed: in idle, a zero base is judged at once on the live request
    always_comb begin
        dec_force = (state_q == XL_IDLE);
        dec_entry = dec_force ? '0 : mem_rsp_data;
        dec_off   = dec_force ? req_va[PAGE_SHIFT-1:0] : va_q[PAGE_SHIFT-1:0];
    end

    // Request capture and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_q   <= '0;
            addr_q <= '0;
            pa_q   <= '0;
            flag_q <= '0;
        end else begin
            if (state_q == XL_IDLE && req_valid) begin
                va_q   <= req_va;
                addr_q <= entry_addr;
                if (base_zero) begin
                    pa_q   <= dec_pa;
                    flag_q <= dec_flags;
                end
            end
            if (state_q == XL_AWAIT && mem_rsp_valid) begin
                pa_q   <= dec_pa;
                flag_q <= dec_flags;
            end
        end
    end

    assign mem_rd_addr  = addr_q;
    assign resp_pa      = pa_q;
    assign resp_fault   = flag_q.fault;
    assign resp_nonsec  = flag_q.nonsec;
    assign resp_page_va = {va_q[ADDR_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};

endmodule

// File: rtl/pt_xlate_top.sv
module pt_xlate_top
    import pt_xlate_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int PAGE_SHIFT  = 12,
    parameter int ENTRY_SHIFT = 2,
    parameter int VALID_BIT   = 1,
    parameter int NONSEC_BIT  = 3,
    parameter int PROT_SHIFT  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tbl_base_wr,
    input  logic [ADDR_W-1:0] tbl_base_in,
    input  logic [ADDR_W-1:0] prot_addr,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_va,
    output logic              resp_valid,
    input  logic              resp_ready,
    output logic [ADDR_W-1:0] resp_pa,
    output logic              resp_fault,
    output logic              resp_nonsec,
    output logic [ADDR_W-1:0] resp_page_va,
    output logic              mem_rd_valid,
    input  logic              mem_rd_ready,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_data
);
    logic [ADDR_W-1:0]     base_q;
    logic                  base_zero;
    logic [ADDR_W-1:0]     entry_addr;
    logic [ADDR_W-1:0]     dec_entry;
    logic                  dec_force;
    logic [PAGE_SHIFT-1:0] dec_off;
    logic [ADDR_W-1:0]     dec_pa;
    xl_flags_t             dec_flags;

    pt_base_reg #(
        .ADDR_W      (ADDR_W),
        .ENTRY_SHIFT (ENTRY_SHIFT)
    ) u_base (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (tbl_base_wr),
        .base_in      (tbl_base_in),
        .base_q       (base_q),
        .base_is_zero (base_zero)
    );

    pt_entry_addr #(
        .ADDR_W      (ADDR_W),
        .PAGE_SHIFT  (PAGE_SHIFT),
        .ENTRY_SHIFT (ENTRY_SHIFT)
    ) u_addr (
        .vpn        (req_va[ADDR_W-1:PAGE_SHIFT]),
        .base       (base_q),
        .entry_addr (entry_addr)
    );

    pt_entry_decode #(
        .ADDR_W     (ADDR_W),
        .PAGE_SHIFT (PAGE_SHIFT),
        .VALID_BIT  (VALID_BIT),
        .NONSEC_BIT (NONSEC_BIT),
        .PROT_SHIFT (PROT_SHIFT)
    ) u_dec (
        .entry       (dec_entry),
        .va_off      (dec_off),
        .force_fault (dec_force),
        .prot_addr   (prot_addr),
        .pa          (dec_pa),
        .flags       (dec_flags)
    );

    pt_walk_fsm #(
        .ADDR_W     (ADDR_W),
        .PAGE_SHIFT (PAGE_SHIFT)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_va        (req_va),
        .base_zero     (base_zero),
        .entry_addr    (entry_addr),
        .mem_rd_valid  (mem_rd_valid),
        .mem_rd_ready  (mem_rd_ready),
        .mem_rd_addr   (mem_rd_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .dec_entry     (dec_entry),
        .dec_force     (dec_force),
        .dec_off       (dec_off),
        .dec_pa        (dec_pa),
        .dec_flags     (dec_flags),
        .resp_valid    (resp_valid),
        .resp_ready    (resp_ready),
        .resp_pa       (resp_pa),
        .resp_fault    (resp_fault),
        .resp_nonsec   (resp_nonsec),
        .resp_page_va  (resp_page_va)
    );

endmodule

// File: rtl/pt_xlate_chk.sv
module pt_xlate_chk #(
    parameter int ADDR_W      = 32,
    parameter int PAGE_SHIFT  = 12,
    parameter int ENTRY_SHIFT = 2,
    parameter int VALID_BIT   = 1,
    parameter int PROT_SHIFT  = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tbl_base_wr,
    input logic [ADDR_W-1:0] tbl_base_in,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_va,
    input logic              resp_valid,
    input logic              resp_ready,
    input logic [ADDR_W-1:0] resp_pa,
    input logic              resp_fault,
    input logic              resp_nonsec,
    input logic [ADDR_W-1:0] resp_page_va,
    input logic              mem_rd_valid,
    input logic              mem_rd_ready,
    input logic [ADDR_W-1:0] mem_rd_addr,
    input logic              mem_rsp_valid,
    input logic [ADDR_W-1:0] mem_rsp_data
);
    localparam logic [ADDR_W-1:0] WORD_MASK = ~ADDR_W'((1 << ENTRY_SHIFT) - 1);

    logic [ADDR_W-1:0] base_m;
    logic [ADDR_W-1:0] cap_va;
    logic [ADDR_W-1:0] cap_base;
    logic              await_q;
    logic              accept;
    logic              word_bad;

    assign accept   = req_valid && req_ready;
    assign word_bad = (mem_rsp_data == '0) || !mem_rsp_data[VALID_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_m   <= '0;
            cap_va   <= '0;
            cap_base <= '0;
            await_q  <= 1'b0;
        end else begin
            if (tbl_base_wr) base_m <= tbl_base_in & WORD_MASK;
            if (accept) begin
                cap_va   <= req_va;
                cap_base <= base_m;
            end
            if (mem_rd_valid && mem_rd_ready) await_q <= 1'b1;
            else if (mem_rsp_valid)           await_q <= 1'b0;
        end
    end

    AST_ENTRY_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> mem_rd_addr == cap_base + ((cap_va >> PAGE_SHIFT) << ENTRY_SHIFT)); // R2

    AST_SINGLE_INFLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid || mem_rd_valid || await_q) |-> !req_ready); // R3

    AST_GOOD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (await_q && mem_rsp_valid && !word_bad) |=>
            resp_valid && !resp_fault &&
            resp_pa[ADDR_W-1:PAGE_SHIFT] == $past(mem_rsp_data[ADDR_W-1:PAGE_SHIFT])); // R4

    AST_PAGE_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_fault) |-> resp_pa[PAGE_SHIFT-1:0] == cap_va[PAGE_SHIFT-1:0]); // R4

    AST_BAD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (await_q && mem_rsp_valid && word_bad) |=> resp_valid && resp_fault); // R5

    AST_FAULT_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_fault) |-> resp_pa[PROT_SHIFT-1:0] == '0); // R6

    AST_ZERO_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && base_m == '0) |=> resp_valid && resp_fault && !mem_rd_valid); // R7

    AST_NONSEC_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_fault) |-> !resp_nonsec); // R8

    AST_PAGE_VA: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> resp_page_va == ((cap_va >> PAGE_SHIFT) << PAGE_SHIFT)); // R9

    AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ready) |=> mem_rd_valid && $stable(mem_rd_addr)); // R10

    AST_RESP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_ready) |=>
            resp_valid && $stable(resp_pa) && $stable(resp_fault) && $stable(resp_nonsec)); // R10

endmodule

bind pt_xlate_top pt_xlate_chk #(
    .ADDR_W      (ADDR_W),
    .PAGE_SHIFT  (PAGE_SHIFT),
    .ENTRY_SHIFT (ENTRY_SHIFT),
    .VALID_BIT   (VALID_BIT),
    .PROT_SHIFT  (PROT_SHIFT)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .tbl_base_wr   (tbl_base_wr),
    .tbl_base_in   (tbl_base_in),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_va        (req_va),
    .resp_valid    (resp_valid),
    .resp_ready    (resp_ready),
    .resp_pa       (resp_pa),
    .resp_fault    (resp_fault),
    .resp_nonsec   (resp_nonsec),
    .resp_page_va  (resp_page_va),
    .mem_rd_valid  (mem_rd_valid),
    .mem_rd_ready  (mem_rd_ready),
    .mem_rd_addr   (mem_rd_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data)
);

// File: tb/pt_xlate_top_bench.sv
`timescale 1ns/1ps
module pt_xlate_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tbl_base_wr = 1'b0;
    logic [31:0] tbl_base_in = '0;
    logic [31:0] prot_addr = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_va = '0;
    logic        resp_valid;
    logic        resp_ready = 1'b0;
    logic [31:0] resp_pa;
    logic        resp_fault;
    logic        resp_nonsec;
    logic [31:0] resp_page_va;
    logic        mem_rd_valid;
    logic        mem_rd_ready = 1'b0;
    logic [31:0] mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    int          vectors = 0;
    int          miscompares = 0;
    int          rd_count = 0;
    int          rd_dly = 0;
    int          rsp_lat = 0;
    logic [31:0] exp_rd_addr = '0;
    logic [31:0] base_m = '0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    pt_xlate_top u_pt_xlate_top (
        .clk           (clk),
        .rst_n         (rst_n),
        .tbl_base_wr   (tbl_base_wr),
        .tbl_base_in   (tbl_base_in),
        .prot_addr     (prot_addr),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_va        (req_va),
        .resp_valid    (resp_valid),
        .resp_ready    (resp_ready),
        .resp_pa       (resp_pa),
        .resp_fault    (resp_fault),
        .resp_nonsec   (resp_nonsec),
        .resp_page_va  (resp_page_va),
        .mem_rd_valid  (mem_rd_valid),
        .mem_rd_ready  (mem_rd_ready),
        .mem_rd_addr   (mem_rd_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data)
    );

    // Table contents as a pure function of the word address:
    // word index 31 mod 32 is all zero, 13 mod 32 lacks the valid bit, the rest are valid.
    function automatic logic [31:0] pte_of(input logic [31:0] a);
        logic [19:0] fr;
        fr = a[21:2] * 20'd37 + 20'd11;
        case (a[6:2])
            5'd31:   return 32'h0;
            5'd13:   return {fr, 12'h008};
            default: return {fr, 8'h00, a[7], 1'b0, 1'b1, 1'b0};
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Memory responder
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && mem_rd_valid) begin
                logic [31:0] a;
                for (int k = 0; k < rd_dly; k++) begin
                    @(negedge clk);
                    check(mem_rd_valid && mem_rd_addr == exp_rd_addr, "R10 read request held",
                          mem_rd_addr, exp_rd_addr);
                end
                check(mem_rd_addr == exp_rd_addr, "R2 table word address", mem_rd_addr, exp_rd_addr);
                a = mem_rd_addr;
                mem_rd_ready = 1'b1;
                rd_count++;
                @(negedge clk);
                mem_rd_ready = 1'b0;
                for (int k = 0; k < rsp_lat; k++) begin
                    mem_rsp_data = 32'hDEAD_BEE0;
                    @(negedge clk);
                end
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = pte_of(a);
                @(negedge clk);
                mem_rsp_valid = 1'b0;
                mem_rsp_data  = 32'h0BAD_F00D;
            end
        end
    end

    task automatic set_base(input logic [31:0] v);
        @(negedge clk);
        tbl_base_wr = 1'b1;
        tbl_base_in = v;
        @(negedge clk);
        tbl_base_wr = 1'b0;
        base_m = v & 32'hFFFF_FFFC;
    endtask

    task automatic xlate(input logic [31:0] va, input int hold, input bit mid_wr, input logic [31:0] mid_base);
        logic [31:0] addr, w, e_pa, pa0;
        bit          zb, e_fault, e_ns;
        int          rc0;
        string       ftag;
        zb      = (base_m == 0);
        addr    = base_m + {10'b0, va[31:12], 2'b00};
        w       = pte_of(addr);
        e_fault = zb || (w == 0) || !w[1];
        e_pa    = e_fault ? (prot_addr & 32'hFFFF_FF80) : {w[31:12], va[11:0]};
        e_ns    = !e_fault && w[3];
        ftag    = zb ? "R7 zero base fault" : (e_fault ? "R5 bad word fault" : "R4 good word no fault");
        exp_rd_addr = addr;
        rc0     = rd_count;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_va    = va;
        @(negedge clk);
        req_valid = 1'b0;
        req_va    = ~va;
        check(!req_ready, "R3 busy after accept", {31'b0, req_ready}, 32'h0);
        if (mid_wr) begin
            tbl_base_wr = 1'b1;
            tbl_base_in = mid_base;
            @(negedge clk);
            tbl_base_wr = 1'b0;
            base_m = mid_base & 32'hFFFF_FFFC;
        end
        while (!resp_valid) @(negedge clk);
        pa0 = resp_pa;
        for (int k = 0; k < hold; k++) begin
            @(negedge clk);
            check(resp_valid && resp_pa == pa0, "R10 response held", resp_pa, pa0);
        end
        check(resp_fault == e_fault, ftag, {31'b0, resp_fault}, {31'b0, e_fault});
        check(resp_pa == e_pa, e_fault ? "R6 redirect address" : "R4 physical address", resp_pa, e_pa);
        check(resp_nonsec == e_ns, "R8 non-secure flag", {31'b0, resp_nonsec}, {31'b0, e_ns});
        check(resp_page_va == {va[31:12], 12'h000}, "R9 page virtual address", resp_page_va, {va[31:12], 12'h000});
        check(rd_count - rc0 == (zb ? 0 : 1), zb ? "R7 no memory read" : "R2 one memory read",
              32'(rd_count - rc0), zb ? 32'd0 : 32'd1);
        resp_ready = 1'b1;
        @(negedge clk);
        resp_ready = 1'b0;
        check(req_ready && !resp_valid, "R3 idle after response", {30'b0, req_ready, resp_valid}, 32'h2);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] bases [4];
        bases[0] = 32'h0040_0000;
        bases[1] = 32'h8000_1003;
        bases[2] = 32'hFFFF_F000;
        bases[3] = 32'h0012_3450;
        prot_addr = 32'h1234_56FF;
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1, "R1 req_ready at reset", {31'b0, req_ready}, 32'h1);
        check(resp_valid == 1'b0, "R1 resp_valid at reset", {31'b0, resp_valid}, 32'h0);
        check(mem_rd_valid == 1'b0, "R1 mem_rd_valid at reset", {31'b0, mem_rd_valid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !resp_valid && !mem_rd_valid, "R1 idle after reset release",
              {29'b0, req_ready, resp_valid, mem_rd_valid}, 32'h4);

        // Reset base is zero: every request faults without a read (R7)
        for (int i = 0; i < 12; i++) begin
            xlate({i[19:0] * 20'h0_0A31, 12'(i * 12'h1F3)}, i % 3, 1'b0, 32'h0);
        end

        // Sweep table positions under several bases (R2 R4 R5 R6 R8 R9 R10)
        for (int b = 0; b < 4; b++) begin
            set_base(bases[b]);
            prot_addr = 32'h1234_56FF ^ (b << 9) ^ (b * 32'h0101_0000);
            for (int i = 0; i < 48; i++) begin
                rd_dly  = i % 3;
                rsp_lat = (i / 3) % 2;
                xlate({20'(i + b * 20'h1_1000 + (i / 32) * 20'h0_0400), 12'(i * 12'h2B7)}, i % 4, 1'b0, 32'h0);
            end
        end

        // Base rewritten while the read is pending: old address still used (R2)
        rd_dly = 2;
        rsp_lat = 1;
        xlate(32'h0000_5123, 1, 1'b1, 32'h0AB0_0000);
        xlate(32'h0000_5123, 0, 1'b0, 32'h0);

        // Back to zero base (R7)
        set_base(32'h0000_0003);
        xlate(32'h7777_7ABC, 2, 1'b0, 32'h0);

        finish_run();
    end

endmodule